// File: doc/BRIEF.md
# Almost-Empty / Almost-Full Offset Loader

This block sits in the write-clock domain of a FIFO and holds the two threshold offsets used by the almost-empty and almost-full flag comparators. Software or board logic programs the thresholds through one 8-bit program bus. Each qualified load writes a single byte. Four byte registers make up the two offsets: a low and a high byte for the empty offset, and a low and a high byte for the full offset.

A two-bit round-robin pointer picks which byte the next load writes. The pointer keeps its place when loading stops. A later session therefore carries on with the next byte instead of starting over. A mode select is sampled while reset is held. It decides whether loading is allowed at all. In dual-write-enable mode both thresholds stay at their default.

Each offset is presented as a `$clog2(DEPTH)`-bit value: the whole low byte, extended by as many bits of the high byte as the depth needs. When the depth needs eight bits or fewer, only the low bits of the low byte count.

The pointer is a state machine with four states: `SLOT_EMPTY_LO`, `SLOT_EMPTY_HI`, `SLOT_FULL_LO` and `SLOT_FULL_HI`. It has two transitions:
- **advance**: a qualified load moves the pointer to the next state in that list. From `SLOT_FULL_HI` it wraps to `SLOT_EMPTY_LO`.
- **hold**: any cycle without a qualified load leaves the pointer where it is.

Top module: `flag_offset_loader`

## Requirements
- R1: While `rst_n` is low at a rising `clk`, the next state is: both offsets equal 7 (low bytes 0x07, high bytes 0x00), and the pointer is at `SLOT_EMPTY_LO`.
- R2: A load happens at a rising `clk` only when `rst_n` is high, the block is in programming mode, and both `cfg_load_n` and `wr_en_n` are low. Each load copies `prog_data` into exactly one byte register.
- R3: Successive loads fill the bytes in this order: empty low, empty high, full low, full high. The fifth load wraps back to empty low.
- R4: With `cfg_load_n` high, the pointer and all bytes are unchanged. The next load continues with the byte after the last one written.
- R5: With `cfg_load_n` low and `wr_en_n` high, nothing is loaded and the pointer does not advance.
- R6: The value of `dual_wen_sel` at the last rising `clk` with `rst_n` low sets the mode. Value 1 selects dual-write-enable mode: all loads are ignored and both offsets stay 7. Value 0 selects programming mode.
- R7: For an offset width AW = `$clog2(DEPTH)` greater than 8, the offset is `{high_byte[AW-9:0], low_byte}`. Otherwise it is `low_byte[AW-1:0]`. Unused high-byte bits have no effect on the output.
- R8: A byte loaded at a rising `clk` shows on `empty_offset` or `full_offset` right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-domain clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load_n | input | 1 | Active-low offset-load strobe |
| wr_en_n | input | 1 | Active-low write enable, qualifies loads |
| dual_wen_sel | input | 1 | Mode select sampled during reset (1 = dual-write-enable, 0 = programming) |
| prog_data | input | 8 | Program byte |
| empty_offset | output | $clog2(DEPTH) | Almost-empty threshold |
| full_offset | output | $clog2(DEPTH) | Almost-full threshold |

## Verification
The bench builds two copies that share one stimulus stream:
- **DEPTH = 512** gives a 9-bit offset. The high-byte bit becomes visible at the outputs, so writes to the high-byte slots and the full load order can be observed.
- **DEPTH = 64** gives a 6-bit offset. This shows that high-byte loads and low-byte bits 7:6 have no effect on the outputs, while the pointer still steps past the high slots.

Randomly interleaved load, no-op and idle cycles, plus resets in both modes, exercise the wrap and the resumption of interrupted sessions.

// File: rtl/flo_pkg.sv
package flo_pkg;

    typedef enum logic [1:0] {
        SLOT_EMPTY_LO = 2'd0,
        SLOT_EMPTY_HI = 2'd1,
        SLOT_FULL_LO  = 2'd2,
        SLOT_FULL_HI  = 2'd3
    } slot_e;

    localparam int          BYTE_W  = 8;
    localparam int          N_SLOTS = 4;
    localparam logic [7:0]  DEF_LO  = 8'h07;
    localparam logic [7:0]  DEF_HI  = 8'h00;

endpackage

// File: rtl/flo_slot_seq.sv
module flo_slot_seq
    import flo_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_load_n,
    input  logic               wr_en_n,
    input  logic               dual_wen_sel,
    output logic [N_SLOTS-1:0] wr_sel,
    output logic               prog_mode
);

    slot_e slot_q;
    slot_e slot_d;
    logic  load_fire;

    // mode is captured only while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_mode <= ~dual_wen_sel;
        end
    end

    assign load_fire = rst_n && prog_mode && !cfg_load_n && !wr_en_n;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= SLOT_EMPTY_LO;
        end else begin
            slot_q <= slot_d;
        end
    end

    // transitions: advance on a qualified load, hold otherwise
    always_comb begin
        slot_d = slot_q;
        if (load_fire) begin
            unique case (slot_q)
                SLOT_EMPTY_LO: slot_d = SLOT_EMPTY_HI;
                SLOT_EMPTY_HI: slot_d = SLOT_FULL_LO;
                SLOT_FULL_LO:  slot_d = SLOT_FULL_HI;
                SLOT_FULL_HI:  slot_d = SLOT_EMPTY_LO;
            endcase
        end
    end

    // outputs: one write select per slot
    always_comb begin
        wr_sel = '0;
        if (load_fire) begin
            unique case (slot_q)
                SLOT_EMPTY_LO: wr_sel[0] = 1'b1;
                SLOT_EMPTY_HI: wr_sel[1] = 1'b1;
                SLOT_FULL_LO:  wr_sel[2] = 1'b1;
                SLOT_FULL_HI:  wr_sel[3] = 1'b1;
            endcase
        end
    end

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel)) else $error("more than one slot selected"); // R2
    AST_FIRST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (load_fire && slot_q == SLOT_EMPTY_LO) |=> (slot_q == SLOT_EMPTY_HI)) else $error("bad step"); // R3
    AST_WRAP_TO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (load_fire && slot_q == SLOT_FULL_HI) |=> (slot_q == SLOT_EMPTY_LO)) else $error("no wrap"); // R3
    AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load_n || wr_en_n) |=> $stable(slot_q)) else $error("pointer moved"); // R4

endmodule

// File: rtl/flo_offset_bank.sv
module flo_offset_bank
    import flo_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_SLOTS-1:0] wr_sel,
    input  logic [BYTE_W-1:0]  prog_data,
    output logic [AW-1:0]      empty_off,
    output logic [AW-1:0]      full_off
);

    logic [BYTE_W-1:0] bytes_q [N_SLOTS];

    for (genvar i = 0; i < N_SLOTS; i++) begin : g_byte
        localparam logic [BYTE_W-1:0] RST_VAL = (i % 2 == 0) ? DEF_LO : DEF_HI;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bytes_q[i] <= RST_VAL;
            end else if (wr_sel[i]) begin
                bytes_q[i] <= prog_data;
            end
        end
    end

    if (AW > BYTE_W) begin : g_wide
        assign empty_off = {bytes_q[1][AW-BYTE_W-1:0], bytes_q[0]};
        assign full_off  = {bytes_q[3][AW-BYTE_W-1:0], bytes_q[2]};
    end else begin : g_narrow
        assign empty_off = bytes_q[0][AW-1:0];
        assign full_off  = bytes_q[2][AW-1:0];
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel[0] |=> (bytes_q[0] == $past(prog_data))) else $error("byte lost"); // R2

endmodule

// File: rtl/flag_offset_loader.sv
module flag_offset_loader
    import flo_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_load_n,
    input  logic                     wr_en_n,
    input  logic                     dual_wen_sel,
    input  logic [7:0]               prog_data,
    output logic [$clog2(DEPTH)-1:0] empty_offset,
    output logic [$clog2(DEPTH)-1:0] full_offset
);

    localparam int            AW      = $clog2(DEPTH);
    localparam logic [AW-1:0] DEF_OFF = AW'(7);

    logic [N_SLOTS-1:0] wr_sel;
    logic               prog_mode;

    flo_slot_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_load_n   (cfg_load_n),
        .wr_en_n      (wr_en_n),
        .dual_wen_sel (dual_wen_sel),
        .wr_sel       (wr_sel),
        .prog_mode    (prog_mode)
    );

    flo_offset_bank #(.AW(AW)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_sel    (wr_sel),
        .prog_data (prog_data),
        .empty_off (empty_offset),
        .full_off  (full_offset)
    );

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load_n || wr_en_n) |=> ($stable(empty_offset) && $stable(full_offset)))
        else $error("offset changed without load"); // R5
    AST_DUAL_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_mode |-> (empty_offset == DEF_OFF && full_offset == DEF_OFF))
        else $error("offset moved in dual mode"); // R6

endmodule

// File: tb/flag_offset_loader_tb.sv
module flag_offset_loader_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_load_n = 1'b1;
    logic       wr_en_n = 1'b1;
    logic       dual_wen_sel = 1'b0;
    logic [7:0] prog_data = 8'h00;
    logic [8:0] eo_w, fo_w;
    logic [5:0] eo_n, fo_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] m_byte [4];
    int         m_ptr;
    bit         m_prog;

    always #4 clk = ~clk;

    flag_offset_loader #(.DEPTH(512)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_load_n(cfg_load_n), .wr_en_n(wr_en_n),
        .dual_wen_sel(dual_wen_sel), .prog_data(prog_data),
        .empty_offset(eo_w), .full_offset(fo_w));

    flag_offset_loader #(.DEPTH(64)) u_dut_narrow (
        .clk(clk), .rst_n(rst_n), .cfg_load_n(cfg_load_n), .wr_en_n(wr_en_n),
        .dual_wen_sel(dual_wen_sel), .prog_data(prog_data),
        .empty_offset(eo_n), .full_offset(fo_n));

    function automatic logic [8:0] wide_off(input logic [7:0] lo, input logic [7:0] hi);
        return {hi[0], lo};
    endfunction

    function automatic logic [5:0] narrow_off(input logic [7:0] lo);
        return lo[5:0];
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        logic [8:0] ew, fw;
        logic [5:0] en, fn;
        ew = wide_off(m_byte[0], m_byte[1]);
        fw = wide_off(m_byte[2], m_byte[3]);
        en = narrow_off(m_byte[0]);
        fn = narrow_off(m_byte[2]);
        check(eo_w == ew, {tag, " wide empty"},   int'(eo_w), int'(ew));
        check(fo_w == fw, {tag, " wide full"},    int'(fo_w), int'(fw));
        check(eo_n == en, {tag, " narrow empty"}, int'(eo_n), int'(en));
        check(fo_n == fn, {tag, " narrow full"},  int'(fo_n), int'(fn));
    endtask

    // one clock: drive at negedge, update the model at the edge, sample after it
    task automatic step(input bit rst, input bit ld, input bit we, input bit sel,
                        input logic [7:0] d, input string tag);
        @(negedge clk);
        rst_n = rst; cfg_load_n = ld; wr_en_n = we; dual_wen_sel = sel; prog_data = d;
        @(posedge clk);
        if (!rst) begin
            m_prog = !sel;
            m_byte[0] = 8'h07; m_byte[1] = 8'h00; m_byte[2] = 8'h07; m_byte[3] = 8'h00;
            m_ptr = 0;
        end else if (m_prog && !ld && !we) begin
            m_byte[m_ptr] = d;
            m_ptr = (m_ptr + 1) % 4;
        end
        #1;
        compare(tag);
    endtask

    task automatic do_reset(input bit sel);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b1, sel, 8'hA5, "R1 reset");
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1D5EED));
        m_prog = 1;
        m_ptr = 0;
        for (int i = 0; i < 4; i++) m_byte[i] = 8'h00;

        // R1: reset defaults
        do_reset(1'b0);
        check(eo_w == 9'd7 && fo_w == 9'd7, "R1 default 7", int'(eo_w), 7);

        // R3/R8: five loads in order, fifth wraps; R7 high bit set
        step(1'b1, 1'b0, 1'b0, 1'b0, 8'hC3, "R8 load empty lo");
        step(1'b1, 1'b0, 1'b0, 1'b0, 8'hFF, "R7 load empty hi");
        check(eo_w == 9'h1C3, "R7 wide compose", int'(eo_w), 'h1C3);
        check(eo_n == 6'h03, "R7 narrow ignores hi", int'(eo_n), 'h03);
        step(1'b1, 1'b0, 1'b0, 1'b0, 8'h5A, "R3 load full lo");
        step(1'b1, 1'b0, 1'b0, 1'b0, 8'h02, "R3 load full hi");
        check(fo_w == 9'h05A, "R7 hi bit1 ignored", int'(fo_w), 'h05A);
        step(1'b1, 1'b0, 1'b0, 1'b0, 8'h11, "R3 wrap to empty lo");
        check(eo_w == 9'h111, "R3 wrap target", int'(eo_w), 'h111);

        // R5: no-op with write enable high, then R4: interruption keeps place
        step(1'b1, 1'b0, 1'b1, 1'b0, 8'h99, "R5 no-op");
        step(1'b1, 1'b1, 1'b0, 1'b0, 8'h98, "R4 idle");
        step(1'b1, 1'b1, 1'b1, 1'b0, 8'h97, "R4 idle");
        step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R4 resume empty hi");
        check(eo_w == 9'h011, "R4 resumed at empty hi", int'(eo_w), 'h011);

        // R1: reset returns pointer to empty low
        do_reset(1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b0, 8'h2C, "R1 first after reset");
        check(eo_w == 9'h02C, "R1 pointer restart", int'(eo_w), 'h02C);

        // R6: dual-write-enable mode ignores loads
        do_reset(1'b1);
        for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 8'hE0 + 8'(i), "R6 dual mode");
        check(eo_w == 9'd7 && fo_w == 9'd7, "R6 defaults kept", int'(fo_w), 7);

        // constrained random in programming mode
        do_reset(1'b0);
        for (int i = 0; i < 600; i++) begin
            int r;
            r = int'($urandom_range(0, 9));
            if (r < 5)      step(1'b1, 1'b0, 1'b0, 1'b0, 8'($urandom), "R2 random load");
            else if (r < 7) step(1'b1, 1'b0, 1'b1, 1'b0, 8'($urandom), "R5 random no-op");
            else if (r < 9) step(1'b1, 1'b1, 1'(r & 1), 1'b1, 8'($urandom), "R4 random idle");
            else            step(1'b1, 1'b1, 1'b0, 1'b0, 8'($urandom), "R4 random idle2");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule